// File: doc/BRIEF.md
# Byte-Wide Counter Channel Register Port

One channel of a 24-bit up/down event counter, reached by a host through an 8-bit port with two addresses: a data address and a control/status address. Count pulses and their direction come from an external decoder. The host cannot write the counter directly. It writes a preset register and then commands a transfer into the counter. It cannot read the live counter either. It commands a snapshot into an output latch and then reads the latch.

Multi-byte values pass through the data address one byte per access, least significant byte first. A shared byte pointer selects the byte and advances after every data access. The control address takes command bytes that reset the pointer, clear or load the counter, take a snapshot and clear flags. Several actions can be combined in one byte. Reading the control address returns a status byte with the borrow and carry toggles, a sticky noise error and the direction of the last count. The XOR of the two toggles extends the count range by one bit.

Top module: `cntr_byte_if`

## Requirements
- R1: After reset the status byte reads 0x00, the byte pointer is at byte 0, and the counter, preset and latch are zero, so three data reads return 0x00 each.
- R2: A data write (`sel_ctrl_i`=0) stores `wdata_i` into the preset byte chosen by the pointer (0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16), then advances the pointer. After byte 2 the pointer wraps to byte 0.
- R3: A data read returns the latch byte chosen by the pointer on `rdata_o` in the same cycle, then advances the pointer with the same wrap. A read on the control address returns the status byte and does not move the pointer.
- R4: A command byte with bit 0 set resets the pointer to byte 0. Bit 4 copies the counter into the output latch. 0x11 does both in one write.
- R5: Command bit 3 (0x08) copies the preset into the counter and leaves the preset unchanged. Bits 2:1 form a clear field: 01 (0x02) clears the counter.
- R6: A pulse on `cnt_pulse_i` adds one to the counter when `cnt_up_i`=1 and subtracts one otherwise. Status bit 5 holds the direction of the last counted pulse (1 = up).
- R7: Counting down from 0 gives 0xFFFFFF and toggles the borrow flag (status bit 0). Counting up from 0xFFFFFF gives 0 and toggles the carry flag (status bit 1).
- R8: Clear field 10 (0x04) clears the borrow and carry flags but not the error flag. Clear field 11 (0x06) clears the error flag (status bit 4). A high `noise_err_i` sets the error flag, and setting takes precedence over clearing. Status bits 2, 3, 6 and 7 read 0.
- R9: A control write is a command only when bits 7:5 are 000 (group 00). Any other value, such as 0x91, 0xA2, 0x28, 0x48, 0x61 or 0xF0, leaves the counter, preset, latch, pointer and flags unchanged.
- R10: A counter load or clear command in the same cycle as a count pulse wins. The pulse is dropped.
- R11: The latch holds its value while the counter changes. A snapshot taken in the same cycle as a count pulse captures the value from before that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ctrl_i | input | 1 | Address select: 1 = control/status, 0 = data |
| wr_i | input | 1 | Host write strobe, one access per cycle |
| rd_i | input | 1 | Host read strobe; ignored while `wr_i` is high |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Read byte: status or latch byte at the pointer |
| cnt_pulse_i | input | 1 | One count event per cycle it is high |
| cnt_up_i | input | 1 | Count direction, 1 = up |
| noise_err_i | input | 1 | Sets the sticky error flag |

## Verification
Every write, command and count pulse sampled at a rising edge shows its effect one cycle later. `rdata_o` is combinational from the registered state, so a read returns the current byte in the cycle of the strobe, and the pointer moves at the edge that ends that access. The bench drives each access at a falling edge and samples `rdata_o` shortly after it, before the next rising edge. Counter values are observed only through a snapshot command followed by three data reads. The same-cycle cases (load with pulse, snapshot with pulse) therefore show the one-cycle ordering at the ports.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  localparam int unsigned BYTE_W = 8;

  // bits 2:1 of a group-00 command byte
  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_CNT  = 2'b01,
    CLR_TOG  = 2'b10,
    CLR_ERR  = 2'b11
  } clr_fld_e;

  typedef struct packed {
    logic rst_ptr;
    logic clr_cnt;
    logic clr_tog;
    logic clr_err;
    logic ld_preset;
    logic xfer_latch;
  } cmd_t;

  localparam int unsigned ST_BT  = 0;
  localparam int unsigned ST_CT  = 1;
  localparam int unsigned ST_ERR = 4;
  localparam int unsigned ST_DIR = 5;
endpackage

// File: rtl/cbi_cmd_dec.sv
module cbi_cmd_dec
  import cbi_pkg::*;
(
  input  logic              en_i,
  input  logic [BYTE_W-1:0] byte_i,
  output cmd_t              cmd_o
);
  logic     hit;
  clr_fld_e fld;

  assign hit = en_i && (byte_i[7:5] == 3'b000);
  assign fld = clr_fld_e'(byte_i[2:1]);

  always_comb begin
    cmd_o            = '0;
    cmd_o.rst_ptr    = hit && byte_i[0];
    cmd_o.ld_preset  = hit && byte_i[3];
    cmd_o.xfer_latch = hit && byte_i[4];
    cmd_o.clr_cnt    = hit && (fld == CLR_CNT);
    cmd_o.clr_tog    = hit && (fld == CLR_TOG);
    cmd_o.clr_err    = hit && (fld == CLR_ERR);
  end
endmodule

// File: rtl/cbi_byte_ptr.sv
module cbi_byte_ptr #(
  parameter int unsigned NUM_BYTES = 3,
  localparam int unsigned PW = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [PW-1:0] ptr_o
);
  localparam logic [PW-1:0] LAST = PW'(NUM_BYTES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (clr_i) ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/cbi_count_core.sv
module cbi_count_core #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_i,
  input  logic             clr_tog_i,
  input  logic             pulse_i,
  input  logic             up_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bt_o,
  output logic             ct_o,
  output logic             dir_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  logic step;
  assign step = pulse_i && !load_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (clr_i)  cnt_o <= '0;
    else if (step)   cnt_o <= up_i ? cnt_o + 1'b1 : cnt_o - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bt_o  <= 1'b0;
      ct_o  <= 1'b0;
      dir_o <= 1'b0;
    end else begin
      if (step) dir_o <= up_i;
      if (clr_tog_i) begin
        bt_o <= 1'b0;
        ct_o <= 1'b0;
      end else if (step) begin
        if (up_i && cnt_o == MAX)   ct_o <= ~ct_o;
        if (!up_i && cnt_o == '0)   bt_o <= ~bt_o;
      end
    end
  end
endmodule

// File: rtl/cntr_byte_if.sv
module cntr_byte_if
  import cbi_pkg::*;
#(
  parameter int unsigned CNT_BYTES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ctrl_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              cnt_pulse_i,
  input  logic              cnt_up_i,
  input  logic              noise_err_i
);
  localparam int unsigned CNT_W = CNT_BYTES * BYTE_W;
  localparam int unsigned PW    = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1;

  cmd_t                             cmd;
  logic [PW-1:0]                    ptr_q;
  logic [CNT_BYTES-1:0][BYTE_W-1:0] preset_q;
  logic [CNT_BYTES-1:0][BYTE_W-1:0] latch_q;
  logic [CNT_W-1:0]                 cnt_q;
  logic                             bt_q, ct_q, dir_q, err_q;
  logic                             data_wr, data_rd;

  assign data_wr = wr_i && !sel_ctrl_i;
  assign data_rd = rd_i && !wr_i && !sel_ctrl_i;

  cbi_cmd_dec u_dec (
    .en_i   (wr_i && sel_ctrl_i),
    .byte_i (wdata_i),
    .cmd_o  (cmd)
  );

  cbi_byte_ptr #(.NUM_BYTES(CNT_BYTES)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cmd.rst_ptr),
    .adv_i  (data_wr || data_rd),
    .ptr_o  (ptr_q)
  );

  cbi_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cmd.ld_preset),
    .load_val_i (preset_q),
    .clr_i      (cmd.clr_cnt),
    .clr_tog_i  (cmd.clr_tog),
    .pulse_i    (cnt_pulse_i),
    .up_i       (cnt_up_i),
    .cnt_o      (cnt_q),
    .bt_o       (bt_q),
    .ct_o       (ct_q),
    .dir_o      (dir_q)
  );

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        preset_q[b] <= '0;
        latch_q[b]  <= '0;
      end else begin
        if (data_wr && ptr_q == PW'(b)) preset_q[b] <= wdata_i;
        if (cmd.xfer_latch)             latch_q[b]  <= cnt_q[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          err_q <= 1'b0;
    else if (noise_err_i) err_q <= 1'b1;
    else if (cmd.clr_err) err_q <= 1'b0;
  end

  logic [BYTE_W-1:0] status;
  always_comb begin
    status         = '0;
    status[ST_BT]  = bt_q;
    status[ST_CT]  = ct_q;
    status[ST_ERR] = err_q;
    status[ST_DIR] = dir_q;
  end

  assign rdata_o = sel_ctrl_i ? status : latch_q[ptr_q];
endmodule

// File: rtl/cntr_byte_if_chk.sv
module cntr_byte_if_chk #(
  parameter int unsigned CNT_BYTES = 3,
  localparam int unsigned CNT_W = CNT_BYTES * 8,
  localparam int unsigned PW    = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_ctrl_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [7:0]       wdata_i,
  input logic             cnt_pulse_i,
  input logic             cnt_up_i,
  input logic             noise_err_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] preset_q,
  input logic [CNT_W-1:0] latch_q,
  input logic [PW-1:0]    ptr_q,
  input logic             ct_q,
  input logic             err_q
);
  logic cmd_v, foreign, ld, clr, ctog;
  assign cmd_v   = wr_i && sel_ctrl_i && (wdata_i[7:5] == 3'b000);
  assign foreign = wr_i && sel_ctrl_i && (wdata_i[7:5] != 3'b000);
  assign ld      = cmd_v && wdata_i[3];
  assign clr     = cmd_v && (wdata_i[2:1] == 2'b01);
  assign ctog    = cmd_v && (wdata_i[2:1] == 2'b10);

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q < PW'(CNT_BYTES)); // R2

  AST_PRESET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> cnt_q == $past(preset_q)); // R5

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !ld) |=> cnt_q == '0); // R5

  AST_LOAD_BEATS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld && cnt_pulse_i) |=> cnt_q == $past(preset_q)); // R10

  AST_LATCH_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_v && wdata_i[4]) |=> latch_q == $past(cnt_q)); // R4

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_v && wdata_i[4]) |=> $stable(latch_q)); // R11

  AST_CARRY_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_pulse_i && cnt_up_i && cnt_q == '1 && !ld && !clr && !ctog)
      |=> (ct_q != $past(ct_q)) && cnt_q == '0); // R7

  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noise_err_i |=> err_q); // R8

  AST_FOREIGN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (foreign && !cnt_pulse_i && !noise_err_i)
      |=> $stable(cnt_q) && $stable(ptr_q) && $stable(latch_q)
          && $stable(preset_q) && $stable(ct_q) && $stable(err_q)); // R9
endmodule

bind cntr_byte_if cntr_byte_if_chk #(.CNT_BYTES(CNT_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_ctrl_i  (sel_ctrl_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .wdata_i     (wdata_i),
  .cnt_pulse_i (cnt_pulse_i),
  .cnt_up_i    (cnt_up_i),
  .noise_err_i (noise_err_i),
  .cnt_q       (cnt_q),
  .preset_q    (preset_q),
  .latch_q     (latch_q),
  .ptr_q       (ptr_q),
  .ct_q        (ct_q),
  .err_q       (err_q)
);

// File: tb/cntr_byte_if_test.sv
`timescale 1ns/1ps
module cntr_byte_if_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_ctrl = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pulse = 1'b0, up = 1'b0, noise = 1'b0;
  int         checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  cntr_byte_if uut (
    .clk_i (clk), .rst_ni (rst_ni), .sel_ctrl_i (sel_ctrl), .wr_i (wr),
    .rd_i (rd), .wdata_i (wdata), .rdata_o (rdata), .cnt_pulse_i (pulse),
    .cnt_up_i (up), .noise_err_i (noise)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctrl_wr(logic [7:0] b);
    sel_ctrl = 1'b1; wr = 1'b1; wdata = b;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic ctrl_wr_pulse(logic [7:0] b, logic dir);
    sel_ctrl = 1'b1; wr = 1'b1; wdata = b; pulse = 1'b1; up = dir;
    @(negedge clk); wr = 1'b0; pulse = 1'b0;
  endtask

  task automatic data_wr(logic [7:0] b);
    sel_ctrl = 1'b0; wr = 1'b1; wdata = b;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic data_rd(output logic [7:0] b);
    sel_ctrl = 1'b0; rd = 1'b1; #1; b = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic status_rd(output logic [7:0] b);
    sel_ctrl = 1'b1; rd = 1'b1; #1; b = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic read3(output logic [23:0] v);
    logic [7:0] b;
    for (int i = 0; i < 3; i++) begin
      data_rd(b); v[i*8 +: 8] = b;
    end
  endtask

  task automatic read24(output logic [23:0] v);
    ctrl_wr(8'h11);
    read3(v);
  endtask

  task automatic set_count(logic [23:0] v);
    ctrl_wr(8'h01);
    for (int i = 0; i < 3; i++) data_wr(v[i*8 +: 8]);
    ctrl_wr(8'h08);
  endtask

  task automatic pulses(logic dir, int n);
    up = dir;
    for (int i = 0; i < n; i++) begin
      pulse = 1'b1; @(negedge clk);
    end
    pulse = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] s; logic [23:0] v;
    status_rd(s); chk("R1 status after reset", s, 8'h00);
    read3(v);     chk("R1 latch after reset", v, 24'h0);
  endtask

  task automatic t_load();
    logic [23:0] v;
    set_count(24'h123456);
    read24(v); chk("R2 R4 R5 preset to counter to latch", v, 24'h123456);
  endtask

  task automatic t_ptr_wrap();
    logic [7:0] b0, b3; logic [23:0] v; logic [7:0] s;
    ctrl_wr(8'h01);
    data_wr(8'hAA); data_wr(8'hBB); data_wr(8'hCC); data_wr(8'hDD);
    ctrl_wr(8'h08);
    read24(v); chk("R2 write pointer wraps to byte 0", v, 24'hCCBBDD);
    ctrl_wr(8'h01);
    data_rd(b0);
    status_rd(s);
    data_rd(b3); chk("R3 status read leaves pointer", b3, 8'hBB);
    data_rd(b3); data_rd(b3);
    chk("R3 read pointer wraps", b3, b0);
  endtask

  task automatic t_count();
    logic [23:0] v; logic [7:0] s;
    set_count(24'h00000A);
    pulses(1'b1, 5);
    read24(v);    chk("R6 count up", v, 24'h00000F);
    status_rd(s); chk("R6 direction up", s, 8'h20);
    pulses(1'b0, 3);
    read24(v);    chk("R6 count down", v, 24'h00000C);
    status_rd(s); chk("R6 direction down", s, 8'h00);
  endtask

  task automatic t_wrap();
    logic [23:0] v; logic [7:0] s;
    set_count(24'h0);
    pulses(1'b0, 1);
    read24(v);    chk("R7 underflow value", v, 24'hFFFFFF);
    status_rd(s); chk("R7 borrow toggle", s, 8'h01);
    pulses(1'b1, 1);
    read24(v);    chk("R7 overflow value", v, 24'h0);
    status_rd(s); chk("R7 carry toggle", s, 8'h23);
    ctrl_wr(8'h04);
    status_rd(s); chk("R8 toggles cleared", s, 8'h20);
  endtask

  task automatic t_noise();
    logic [7:0] s;
    noise = 1'b1; @(negedge clk); noise = 1'b0;
    status_rd(s); chk("R8 error set", s, 8'h30);
    ctrl_wr(8'h04);
    status_rd(s); chk("R8 0x04 keeps error", s, 8'h30);
    ctrl_wr(8'h06);
    status_rd(s); chk("R8 0x06 clears error", s, 8'h20);
  endtask

  task automatic t_clear();
    logic [23:0] v;
    set_count(24'h00ABCD);
    ctrl_wr(8'h02);
    read24(v); chk("R5 clear counter", v, 24'h0);
    ctrl_wr(8'h08);
    read24(v); chk("R5 preset kept after load", v, 24'h00ABCD);
  endtask

  task automatic t_ignore();
    logic [23:0] v; logic [7:0] s;
    set_count(24'h000777);
    read24(v);
    pulses(1'b1, 1);
    ctrl_wr(8'h91); ctrl_wr(8'hA2); ctrl_wr(8'h28);
    ctrl_wr(8'h48); ctrl_wr(8'h61); ctrl_wr(8'hF0);
    read3(v);     chk("R9 latch and pointer untouched", v, 24'h000777);
    status_rd(s); chk("R9 flags untouched", s, 8'h20);
    read24(v);    chk("R9 counter untouched", v, 24'h000778);
    ctrl_wr(8'h08);
    read24(v);    chk("R9 preset untouched", v, 24'h000777);
  endtask

  task automatic t_prio();
    logic [23:0] v;
    set_count(24'h000040);
    pulses(1'b1, 2);
    ctrl_wr_pulse(8'h08, 1'b1);
    read24(v); chk("R10 load beats pulse", v, 24'h000040);
    ctrl_wr_pulse(8'h02, 1'b1);
    read24(v); chk("R10 clear beats pulse", v, 24'h0);
    ctrl_wr_pulse(8'h10, 1'b1);
    read3(v);  chk("R11 snapshot before pulse", v, 24'h0);
    pulses(1'b1, 3);
    read3(v);  chk("R11 latch holds", v, 24'h0);
    read24(v); chk("R11 counter moved on", v, 24'h000004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_ptr_wrap();
    t_count();
    t_wrap();
    t_noise();
    t_clear();
    t_ignore();
    t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule